// File: doc/BRIEF.md
# Raster Sync Generator with Pixel Stream Sink

This block produces the line and frame timing for a panel display clocked by its pixel clock. Two position counters walk across each line and down each frame. From their values the block derives active-low horizontal and vertical sync pulses and active-high blanking flags. Every line and every frame runs in a fixed order: the visible span first, then the front porch, then the sync pulse, then the back porch. The lengths of all four spans are parameters. The defaults describe an 800x480 panel: a line of 1056 clocks and a frame of 525 lines.

Pixels arrive as 32-bit words on a valid/ready sink. The block accepts a word on every clock outside blanking. Outside blanking, the low three bytes of the word drive the red, green and blue outputs. During blanking those outputs are held at black. A one-register memory-mapped read port lets a processor poll the blanking state. A frame-sync output marks vertical blanking for a downstream frame reader, which can use its rising edge to rewind to the first pixel.

Top module: `raster_timing_sink`

## Requirements
- R1: While reset is high at a clock edge, both position counters go to zero. After that edge, hsync_n and vsync_n are 1, hblank and vblank are 0, and in_ready is 1.
- R2: The horizontal position x counts 0 to H_TOTAL-1 (H_TOTAL = H_VIS+H_FP+H_SYNC+H_BP) and then wraps to 0. hblank is 1 exactly when x >= H_VIS.
- R3: hsync_n is 0 exactly when H_VIS+H_FP <= x < H_VIS+H_FP+H_SYNC.
- R4: The line index y advances on the clock where x wraps, and wraps to 0 after V_TOTAL lines. vblank is 1 exactly when y >= V_VIS, so vblank changes only at the start of a line.
- R5: vsync_n is 0 exactly when V_VIS+V_FP <= y < V_VIS+V_FP+V_SYNC.
- R6: With both blanks low, red = in_data[23:16], green = in_data[15:8] and blue = in_data[7:0]; in_data[31:24] has no effect. With either blank high, all three colour outputs are 0.
- R7: in_ready is 1 exactly when hblank and vblank are both 0; a word is taken on any clock where in_valid and in_ready are both 1.
- R8: A read (csr_rd = 1) places its result on csr_rdata one clock later, with csr_rvalid = 1 in that cycle. Address 1 returns hblank in bit 0 and vblank in bit 1, with all other bits 0. Any other address returns 0. Without a read, csr_rdata is 0 and csr_rvalid is 0.
- R9: frame_sync equals vblank on every cycle.
- R10: A reset asserted in mid-frame restarts the raster at x = 0, y = 0, and timing proceeds from there as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel word offered by the source |
| in_data | input | 32 | Pixel word, red/green/blue in the low three bytes |
| in_ready | output | 1 | Sink accepts a word (no blanking) |
| red | output | 8 | Red channel, 0 during blanking |
| green | output | 8 | Green channel, 0 during blanking |
| blue | output | 8 | Blue channel, 0 during blanking |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | Horizontal blanking, active high |
| vblank | output | 1 | Vertical blanking, active high |
| frame_sync | output | 1 | Vertical blanking marker for a frame reader |
| csr_rd | input | 1 | Status read strobe |
| csr_addr | input | 4 | Status read address |
| csr_rdata | output | 32 | Status read data, one cycle after the strobe |
| csr_rvalid | output | 1 | Read data valid |

## Verification
The hardest state to reach is a full frame boundary. At that point x and y wrap on the same clock, and vertical blanking ends while horizontal blanking is still settling. Hitting it needs a whole frame of free-running cycles, and at the panel size that is over half a million clocks. The bench therefore shrinks every span to a few clocks or lines, so that a frame is 80 cycles. It then sweeps two full frames and more, cycle by cycle. It issues status reads at rotating addresses throughout the sweep and changes the pixel word on every clock. Finally it resets in mid-frame, inside vertical blanking, to check that the raster restarts.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int COLOR_W      = 8;
  localparam int PIX_W        = 32;
  localparam int CSR_W        = 32;
  localparam int STAT_ADDR    = 1;
  localparam int STAT_HB_BIT  = 0;
  localparam int STAT_VB_BIT  = 1;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int VIS  = 800,
  parameter int FP   = 210,
  parameter int SYNC = 30,
  parameter int BP   = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                step,
  output logic [$clog2(VIS+FP+SYNC+BP)-1:0]   pos,
  output logic                                last,
  output logic                                blank,
  output logic                                sync_n
);
  localparam int TOTAL = VIS + FP + SYNC + BP;
  localparam int PW    = $clog2(TOTAL);
  localparam logic [PW-1:0] END_P  = PW'(TOTAL - 1);
  localparam logic [PW-1:0] BLK_P  = PW'(VIS);
  localparam logic [PW-1:0] SYN0_P = PW'(VIS + FP);
  localparam logic [PW-1:0] SYN1_P = PW'(VIS + FP + SYNC);

  function automatic logic blank_of(input logic [PW-1:0] p);
    return p >= BLK_P;
  endfunction

  function automatic logic sync_n_of(input logic [PW-1:0] p);
    return !((p >= SYN0_P) && (p < SYN1_P));
  endfunction

  logic          at_end;
  logic [PW-1:0] pos_nx;

  assign at_end = (pos == END_P);
  assign last   = step && at_end;

  always_comb begin
    pos_nx = pos;
    if (step) pos_nx = at_end ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      blank  <= blank_of('0);
      sync_n <= sync_n_of('0);
    end else begin
      pos    <= pos_nx;
      blank  <= blank_of(pos_nx);
      sync_n <= sync_n_of(pos_nx);
    end
  end
endmodule

// File: rtl/raster_pixel_gate.sv
module raster_pixel_gate
  import raster_pkg::*;
(
  input  logic             hblank,
  input  logic             vblank,
  input  logic [PIX_W-1:0] data,
  output logic             ready,
  output rgb_t             pix
);
  logic             active;
  logic [PIX_W-1:0] unused_gated;

  assign active       = !(hblank || vblank);
  assign ready        = active;
  assign unused_gated = active ? data : '0;
  assign pix          = rgb_t'(unused_gated[3*COLOR_W-1:0]);
endmodule

// File: rtl/raster_status.sv
module raster_status
  import raster_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic             hblank,
  input  logic             vblank,
  output logic [CSR_W-1:0] rdata,
  output logic             rvalid
);
  localparam logic [AW-1:0] HIT = AW'(STAT_ADDR);

  logic [CSR_W-1:0] word;

  always_comb begin
    word = '0;
    word[STAT_HB_BIT] = hblank;
    word[STAT_VB_BIT] = vblank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= (rd && addr == HIT) ? word : '0;
    end
  end
endmodule

// File: rtl/raster_timing_sink.sv
module raster_timing_sink
  import raster_pkg::*;
#(
  parameter int H_VIS  = 800,
  parameter int H_FP   = 210,
  parameter int H_SYNC = 30,
  parameter int H_BP   = 16,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 22,
  parameter int V_SYNC = 13,
  parameter int V_BP   = 10,
  parameter int CSR_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              hblank,
  output logic              vblank,
  output logic              frame_sync,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  output logic [31:0]       csr_rdata,
  output logic              csr_rvalid
);
  localparam int HW = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_VIS + V_FP + V_SYNC + V_BP);

  logic [HW-1:0] x_pos;
  logic [VW-1:0] y_pos;
  logic          line_end;
  logic          unused_frame_end;
  logic          unused_in_valid;
  logic [HW+VW-1:0] unused_pos;
  rgb_t          pix;

  assign unused_in_valid = in_valid;
  assign unused_pos      = {x_pos, y_pos};

  raster_axis #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) h_axis_i (
    .clk(clk), .rst(rst), .step(1'b1),
    .pos(x_pos), .last(line_end), .blank(hblank), .sync_n(hsync_n)
  );

  raster_axis #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) v_axis_i (
    .clk(clk), .rst(rst), .step(line_end),
    .pos(y_pos), .last(unused_frame_end), .blank(vblank), .sync_n(vsync_n)
  );

  raster_pixel_gate gate_i (
    .hblank(hblank), .vblank(vblank), .data(in_data),
    .ready(in_ready), .pix(pix)
  );

  raster_status #(.AW(CSR_AW)) status_i (
    .clk(clk), .rst(rst), .rd(csr_rd), .addr(csr_addr),
    .hblank(hblank), .vblank(vblank),
    .rdata(csr_rdata), .rvalid(csr_rvalid)
  );

  assign red        = pix.r;
  assign green      = pix.g;
  assign blue       = pix.b;
  assign frame_sync = vblank;
endmodule

// File: rtl/raster_timing_sink_chk.sv
module raster_timing_sink_chk #(
  parameter int CSR_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [7:0]        red,
  input logic [7:0]        green,
  input logic [7:0]        blue,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              hblank,
  input logic              vblank,
  input logic              frame_sync,
  input logic              csr_rd,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [31:0]       csr_rdata,
  input logic              csr_rvalid
);
  AST_RGB_BLACK_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    (hblank || vblank) |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0)); // R6
  AST_HSYNC_INSIDE_HBLANK: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> hblank); // R3
  AST_VSYNC_INSIDE_VBLANK: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> vblank); // R5
  AST_VBLANK_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(vblank) || $fell(vblank)) |-> $past(hblank)); // R4
  AST_READY_OUTSIDE_BLANK: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!hblank && !vblank)); // R7
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    csr_rd |=> csr_rvalid); // R8
  AST_READ_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_addr != CSR_AW'(1)) |=> (csr_rdata == 32'd0)); // R8
  AST_FRAME_SYNC_VBLANK: assert property (@(posedge clk) disable iff (rst)
    frame_sync == vblank); // R9
endmodule

bind raster_timing_sink raster_timing_sink_chk #(.CSR_AW(CSR_AW)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .red(red), .green(green),
  .blue(blue), .hsync_n(hsync_n), .vsync_n(vsync_n), .hblank(hblank),
  .vblank(vblank), .frame_sync(frame_sync), .csr_rd(csr_rd),
  .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid)
);

// File: tb/raster_timing_sink_tb.sv
`timescale 1ns/1ps
module raster_timing_sink_tb_top;
  localparam int HV = 4, HF = 2, HS = 3, HB = 1;
  localparam int VV = 3, VF = 1, VS = 2, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [7:0]  red, green, blue;
  logic        hsync_n, vsync_n, hblank, vblank, frame_sync;
  logic        csr_rd = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  raster_timing_sink #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .CSR_AW(4)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .red(red), .green(green), .blue(blue),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .hblank(hblank), .vblank(vblank),
    .frame_sync(frame_sync), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  logic [31:0] exp_rdata = '0;
  logic        exp_rvalid = 1'b0;

  // Runs n cycles after a reset release; t counts clock edges since then.
  task automatic sweep(input int n);
    for (int t = 0; t < n; t++) begin
      int x = t % HT;
      int y = (t / HT) % VT;
      logic hb = (x >= HV);
      logic vb = (y >= VV);
      logic hs = !(x >= HV + HF && x < HV + HF + HS);
      logic vs = !(y >= VV + VF && y < VV + VF + VS);
      logic act = !hb && !vb;
      logic [31:0] d;
      d = {8'(t) ^ 8'hA5, 8'(t * 3), 8'(t * 7 + 1), 8'(t * 11 + 2)};
      in_data  = d;
      in_valid = (t % 5) != 4;
      #1;
      chk("R2", "hblank", 32'(hblank), 32'(hb));
      chk("R3", "hsync_n", 32'(hsync_n), 32'(hs));
      chk("R4", "vblank", 32'(vblank), 32'(vb));
      chk("R5", "vsync_n", 32'(vsync_n), 32'(vs));
      chk("R6", "rgb", {8'd0, red, green, blue}, act ? {8'd0, d[23:0]} : 32'd0);
      chk("R7", "in_ready", 32'(in_ready), 32'(act));
      chk("R9", "frame_sync", 32'(frame_sync), 32'(vb));
      chk("R8", "csr_rdata", csr_rdata, exp_rdata);
      chk("R8", "csr_rvalid", 32'(csr_rvalid), 32'(exp_rvalid));
      csr_rd   = (t % 3) != 2;
      csr_addr = 4'(t % 4);
      exp_rvalid = csr_rd;
      exp_rdata  = (csr_rd && csr_addr == 4'd1) ? {30'd0, vb, hb} : 32'd0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "hsync_n", 32'(hsync_n), 32'd1);
    chk("R1", "vsync_n", 32'(vsync_n), 32'd1);
    chk("R1", "hblank", 32'(hblank), 32'd0);
    chk("R1", "vblank", 32'(vblank), 32'd0);
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    sweep(2 * HT * VT + 35);
    // R10: reset inside vertical blanking, then the raster must restart
    chk("R10", "vblank before reset", 32'(vblank), 32'd1);
    rst = 1'b1;
    csr_rd = 1'b0;
    exp_rdata = '0;
    exp_rvalid = 1'b0;
    @(negedge clk);
    #1;
    chk("R10", "vblank after reset", 32'(vblank), 32'd0);
    chk("R10", "hblank after reset", 32'(hblank), 32'd0);
    chk("R10", "csr_rvalid after reset", 32'(csr_rvalid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    sweep(HT * VT + 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule